// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Engine

This block is the slave side of a small three-wire serial memory holding sixteen 16-bit words. A host raises chip select, clocks a start bit and an 8-bit command word into the data input on rising serial-clock edges, and then either receives read data on the data output or supplies write data. The block samples chip select, serial clock and data input with its own system clock. It detects serial-clock rising edges internally, so the serial clock must run several times slower than the system clock.

Write, erase, write-all and erase-all commands are armed by the serial transfer and carried out only when the host drops chip select. These commands change the array only while a write-enable flag is set. Programming then keeps a busy flag high for a fixed, parameterised number of system clocks. During that time any new traffic is ignored. The storage is a register file inside the block, and reset sets every word to all ones.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset, do_o and busy_o are 0, the write-enable flag is clear, and every word reads back as 16'hFFFF.
- R2: A command begins only after a chip-select rising edge. Zeros clocked on di_i before the first 1 are skipped, and that first 1 is the start bit.
- R3: The 8 bits after the start bit form the command word, MSB first, with the address in bits 3..0. Bits 7..6 select the command: 00 read, 10 write, 01 erase. 11 selects a special command from the low nibble: 0001 enable, 0010 disable, 0100 write-all, 0101 erase-all. Bits 5..4 must be 00. On a read, do_o is 0 after the last command bit, and the next 16 serial-clock edges present the word MSB first.
- R4: After the 16th read bit, the next serial-clock edge switches do_o to follow di_i until chip select falls.
- R5: di_i has no effect on the data returned during read output.
- R6: Write, erase, write-all and erase-all change the array only if the enable flag is set. The enable command (8'hC1) sets it, and the disable command (8'hC2) clears it.
- R7: Write and write-all take 16 data bits, MSB first. Programming starts when chip select goes low after a complete command. busy_o is then high for exactly PROG_CYCLES system clocks.
- R8: Erase sets every bit of the addressed word to 1 and leaves other words unchanged.
- R9: Write-all stores its data in all 16 words, and erase-all sets all 16 words to 16'hFFFF.
- R10: Only one command runs per chip-select assertion. Serial-clock edges after a completed command are ignored until chip select falls and rises again.
- R11: While busy_o is high, chip-select and serial-clock activity is ignored. A chip-select edge that rose during programming does not start a command afterwards.
- R12: After a read, chip select must be low during at least one serial-clock rising edge before a new command is accepted.
- R13: do_o is 0 at all times other than read output and the echo phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output |
| busy_o | output | 1 | High while programming runs |

## Verification
Two functions can overlap. The first is the programming interval, which starts when chip select falls. The second is a new chip-select rise with a full read command clocked in while busy_o is still high. The bench provokes this overlap and checks that do_o stays 0 throughout. It then checks that the programmed word reads back correctly after a fresh chip-select cycle. The read-recovery gap and the end of a read are also made to meet: chip select is re-raised without a low serial-clock edge, and the block must return no data.

// File: rtl/sm_pkg.sv
package sm_pkg;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_ERASE, OP_WEN, OP_WDS, OP_WRALL, OP_ERALL, OP_BAD
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_CMD, ST_DATA, ST_RDOUT, ST_ECHO, ST_HOLD, ST_GAP, ST_PROG
  } state_e;

  function automatic logic is_prog_op(op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_WRALL) || (op == OP_ERALL);
  endfunction

endpackage

// File: rtl/sm_sync.sv
module sm_sync #(
  parameter int STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic cs_rise_o,
  output logic sk_rise_o
);
  // stage chain per input, plus one extra tap for edge detect
  logic [STAGES:0] cs_sr, sk_sr;
  logic [STAGES-1:0] di_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sr <= '0;
      sk_sr <= '0;
      di_sr <= '0;
    end else begin
      cs_sr <= {cs_sr[STAGES-1:0], cs_i};
      sk_sr <= {sk_sr[STAGES-1:0], sk_i};
      di_sr <= {di_sr[STAGES-2+1-1:0], di_i} ;
    end
  end

  assign cs_o      = cs_sr[STAGES-1];
  assign di_o      = di_sr[STAGES-1];
  assign cs_rise_o = cs_sr[STAGES-1] & ~cs_sr[STAGES];
  assign sk_rise_o = sk_sr[STAGES-1] & ~sk_sr[STAGES];

endmodule

// File: rtl/sm_cmd_decode.sv
module sm_cmd_decode
  import sm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W+3:0] word_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OP_W = ADDR_W + 4;

  assign addr_o = word_i[ADDR_W-1:0];

  always_comb begin
    op_o = OP_BAD;
    if (word_i[OP_W-3:ADDR_W] == 2'b00) begin
      case (word_i[OP_W-1:OP_W-2])
        2'b00: op_o = OP_READ;
        2'b10: op_o = OP_WRITE;
        2'b01: op_o = OP_ERASE;
        default: begin
          case (word_i[ADDR_W-1:0])
            ADDR_W'(1): op_o = OP_WEN;
            ADDR_W'(2): op_o = OP_WDS;
            ADDR_W'(4): op_o = OP_WRALL;
            ADDR_W'(5): op_o = OP_ERALL;
            default:    op_o = OP_BAD;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/sm_array.sv
module sm_array #(
  parameter int WORDS  = 16,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '1;
      end else if (wr_en_i && (wr_all_i || (wr_addr_i == ADDR_W'(g)))) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import sm_pkg::*;
#(
  parameter int WORDS       = 16,
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic busy_o
);
  localparam int OP_W   = ADDR_W + 4;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);

  logic cs_s, di_s, cs_rise, sk_rise;

  sm_sync #(.STAGES(1)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_i     (cs_i),
    .sk_i     (sk_i),
    .di_i     (di_i),
    .cs_o     (cs_s),
    .di_o     (di_s),
    .cs_rise_o(cs_rise),
    .sk_rise_o(sk_rise)
  );

  state_e             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [OP_W-2:0]    cmd_q;
  logic [WORD_W-1:0]  data_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [PROG_W-1:0]  prog_q;
  op_e                pend_q;
  logic               wen_q;
  logic               do_q;

  logic [OP_W-1:0]    cmd_nxt;
  op_e                dec_op;
  logic [ADDR_W-1:0]  dec_addr;
  logic [WORD_W-1:0]  rd_data;
  logic               arr_we, arr_all;
  logic [WORD_W-1:0]  arr_data;

  assign cmd_nxt = {cmd_q, di_s};

  sm_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .word_i(cmd_nxt),
    .op_o  (dec_op),
    .addr_o(dec_addr)
  );

  // array commit happens once, on the cycle CS is seen low in HOLD
  assign arr_we   = (state_q == ST_HOLD) && !cs_s && wen_q && is_prog_op(pend_q);
  assign arr_all  = (pend_q == OP_WRALL) || (pend_q == OP_ERALL);
  assign arr_data = ((pend_q == OP_ERASE) || (pend_q == OP_ERALL)) ? '1 : data_q;

  sm_array #(.WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (arr_we),
    .wr_all_i (arr_all),
    .wr_addr_i(addr_q),
    .wr_data_i(arr_data),
    .rd_addr_i(dec_addr),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      prog_q  <= '0;
      pend_q  <= OP_BAD;
      wen_q   <= 1'b0;
      do_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cs_rise) state_q <= ST_START;
        end
        ST_START: begin
          if (!cs_s) state_q <= ST_IDLE;
          else if (sk_rise && di_s) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
        end
        ST_CMD: begin
          if (!cs_s) state_q <= ST_IDLE;
          else if (sk_rise) begin
            cmd_q <= cmd_nxt[OP_W-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(OP_W - 1)) begin
              addr_q <= dec_addr;
              pend_q <= dec_op;
              cnt_q  <= '0;
              case (dec_op)
                OP_READ: begin
                  data_q  <= rd_data;
                  do_q    <= 1'b0;
                  state_q <= ST_RDOUT;
                end
                OP_WRITE, OP_WRALL: state_q <= ST_DATA;
                OP_WEN: begin
                  wen_q   <= 1'b1;
                  state_q <= ST_HOLD;
                end
                OP_WDS: begin
                  wen_q   <= 1'b0;
                  state_q <= ST_HOLD;
                end
                default: state_q <= ST_HOLD;
              endcase
            end
          end
        end
        ST_DATA: begin
          if (!cs_s) state_q <= ST_IDLE;
          else if (sk_rise) begin
            data_q <= {data_q[WORD_W-2:0], di_s};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(WORD_W - 1)) state_q <= ST_HOLD;
          end
        end
        ST_RDOUT: begin
          if (!cs_s) state_q <= ST_GAP;
          else if (sk_rise) begin
            if (cnt_q == CNT_W'(WORD_W)) begin
              state_q <= ST_ECHO;
            end else begin
              do_q   <= data_q[WORD_W-1];
              data_q <= {data_q[WORD_W-2:0], 1'b0};
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_ECHO: begin
          if (!cs_s) state_q <= ST_GAP;
        end
        ST_HOLD: begin
          if (!cs_s) begin
            if (arr_we) begin
              state_q <= ST_PROG;
              prog_q  <= PROG_W'(PROG_CYCLES - 1);
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (sk_rise && !cs_s) state_q <= ST_IDLE;
        end
        ST_PROG: begin
          if (prog_q == '0) state_q <= ST_IDLE;
          else prog_q <= prog_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_RDOUT: do_o = do_q;
      ST_ECHO:  do_o = di_s;
      default:  do_o = 1'b0;
    endcase
  end

  assign busy_o = (state_q == ST_PROG);

endmodule

// File: rtl/sm_slave_chk.sv
module sm_slave_chk
  import sm_pkg::*;
#(
  parameter int PROG_CYCLES = 200
) (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   cs_s_i,
  input logic   sk_rise_i,
  input logic   do_i,
  input logic   busy_i,
  input logic   wen_i,
  input state_e state_i
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else if (busy_i) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (busy_cnt == PROG_CYCLES));

  a_r7_prog_after_cs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !$past(cs_s_i));

  a_r6_prog_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wen_i));

  a_r13_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !do_i);

  a_r3_do_moves_on_sk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RDOUT && $past(state_i) == ST_RDOUT && !$past(sk_rise_i)) |-> $stable(do_i));

  a_r12_gap_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_GAP && state_i != ST_GAP) |-> ($past(sk_rise_i) && !$past(cs_s_i)));

endmodule

bind serial_mem_slave sm_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_s_i   (cs_s),
  .sk_rise_i(sk_rise),
  .do_i     (do_o),
  .busy_i   (busy_o),
  .wen_i    (wen_q),
  .state_i  (state_q)
);

// File: tb/tb_serial_mem_slave.sv
module tb_serial_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 40;
  localparam int WD_CYCLES  = 150000;

  // {addr, data} pairs written then read back
  localparam logic [19:0] WR_VEC [0:5] = '{
    20'h0_8001, 20'h1_7FFE, 20'h5_A5A5, 20'h9_0000, 20'hE_1234, 20'hF_FFFE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0;
  logic do_o, busy_o;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_mem_slave #(.PROG_CYCLES(PROG_CYC)) dut (
    .clk_i (clk), .rst_ni(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .do_o  (do_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic d, output logic q);
    di_i = d;
    repeat (4) @(negedge clk);
    sk_i = 1'b1;
    repeat (4) @(negedge clk);
    q = do_o;
    sk_i = 1'b0;
  endtask

  task automatic select();
    cs_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] w, output logic last_q);
    logic q;
    pulse(1'b1, q);
    for (int i = 7; i >= 0; i--) pulse(w[i], last_q);
  endtask

  task automatic prog_wait(output int n);
    int guard = 0;
    n = 0;
    while (!busy_o && guard < 8) begin
      @(negedge clk);
      guard++;
    end
    while (busy_o) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input bit has_data, input logic [15:0] d,
                         output int busy_n, output logic any_do);
    logic q;
    select();
    send_cmd(op, q);
    any_do = q;
    if (has_data)
      for (int i = 15; i >= 0; i--) begin
        pulse(d[i], q);
        any_do |= q;
      end
    cs_i = 1'b0;
    di_i = 1'b0;
    prog_wait(busy_n);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_word(input logic [3:0] a, output logic [15:0] v, output logic dmy);
    logic q;
    select();
    send_cmd({4'b0000, a}, dmy);
    for (int i = 15; i >= 0; i--) begin
      pulse(i[0], q); // DI toggles during output
      v[i] = q;
    end
    cs_i = 1'b0;
    di_i = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b0, q); // recovery edge with CS low
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic dmy, q, any;
    int bn;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 do after reset", do_o, 0);
    chk("R1 busy after reset", busy_o, 0);
    rd_word(4'h3, v, dmy);
    chk("R1 erased array", v, 16'hFFFF);
    chk("R3 dummy zero", dmy, 0);

    // R6 write refused while enable flag clear
    run_cmd(8'h82, 1, 16'h1234, bn, any);
    chk("R6 no busy without enable", bn, 0);
    rd_word(4'h2, v, dmy);
    chk("R6 word unchanged", v, 16'hFFFF);

    run_cmd(8'hC1, 0, 16'h0, bn, any);
    chk("R6 enable cmd no busy", bn, 0);

    // table walk: R7 programming, R3/R5 readback, R13 quiet DO
    for (int k = 0; k < 6; k++) begin
      run_cmd({4'b1000, WR_VEC[k][19:16]}, 1, WR_VEC[k][15:0], bn, any);
      chk("R7 busy length", bn, PROG_CYC);
      chk("R13 do quiet during write", any, 0);
      rd_word(WR_VEC[k][19:16], v, dmy);
      chk("R3 R5 readback", v, WR_VEC[k][15:0]);
      chk("R3 dummy zero", dmy, 0);
    end

    // R2 leading zeros before start bit
    select();
    pulse(1'b0, q); pulse(1'b0, q); pulse(1'b0, q);
    send_cmd(8'h05, dmy);
    for (int i = 15; i >= 0; i--) begin pulse(1'b0, q); v[i] = q; end
    chk("R2 leading zeros skipped", v, 16'hA5A5);
    // R4 echo
    pulse(1'b1, q);
    chk("R4 echo high", q, 1);
    di_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 echo low", do_o, 0);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 do low after deselect", do_o, 0);
    pulse(1'b0, q);

    // R8 erase single word
    run_cmd(8'h40, 0, 16'h0, bn, any);
    chk("R8 erase busy", bn, PROG_CYC);
    rd_word(4'h0, v, dmy);
    chk("R8 erased word", v, 16'hFFFF);
    rd_word(4'h1, v, dmy);
    chk("R8 neighbour kept", v, 16'h7FFE);

    // R10 one command per CS assertion
    select();
    send_cmd(8'h85, q);
    for (int i = 15; i >= 0; i--) pulse(logic'(16'h0C0C >> i), q);
    send_cmd(8'h86, q);
    for (int i = 15; i >= 0; i--) pulse(logic'(16'h3333 >> i), q);
    cs_i = 1'b0;
    prog_wait(bn);
    repeat (2) @(negedge clk);
    rd_word(4'h5, v, dmy);
    chk("R10 first command applied", v, 16'h0C0C);
    rd_word(4'h6, v, dmy);
    chk("R10 extra command ignored", v, 16'hFFFF);

    // R11 traffic during busy ignored
    select();
    send_cmd(8'h87, q);
    for (int i = 15; i >= 0; i--) pulse(logic'(16'h0F0F >> i), q);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 busy raised", busy_o, 1);
    select();
    send_cmd(8'h01, dmy);
    any = dmy;
    for (int i = 0; i < 16; i++) begin pulse(1'b1, q); any |= q; end
    chk("R11 read during busy silent", any, 0);
    chk("R11 busy finished", busy_o, 0);
    send_cmd(8'h01, dmy);
    any = dmy;
    for (int i = 0; i < 16; i++) begin pulse(1'b1, q); any |= q; end
    chk("R11 stale CS rise unused", any, 0);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    rd_word(4'h7, v, dmy);
    chk("R11 programmed value", v, 16'h0F0F);

    // R12 read recovery gap
    select();
    send_cmd(8'h0E, dmy);
    for (int i = 0; i < 16; i++) pulse(1'b0, q);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    select();
    send_cmd(8'h0F, dmy);
    any = dmy;
    for (int i = 0; i < 16; i++) begin pulse(1'b0, q); any |= q; end
    chk("R12 command without gap ignored", any, 0);
    cs_i = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b0, q);
    rd_word(4'hF, v, dmy);
    chk("R12 read after gap", v, 16'hFFFE);

    // R9 erase-all then write-all
    run_cmd(8'hC5, 0, 16'h0, bn, any);
    chk("R9 erase-all busy", bn, PROG_CYC);
    rd_word(4'h9, v, dmy);
    chk("R9 erase-all word 9", v, 16'hFFFF);
    run_cmd(8'hC4, 1, 16'h5A3C, bn, any);
    chk("R9 write-all busy", bn, PROG_CYC);
    rd_word(4'h0, v, dmy);
    chk("R9 write-all word 0", v, 16'h5A3C);
    rd_word(4'hF, v, dmy);
    chk("R9 write-all word 15", v, 16'h5A3C);

    // R6 disable blocks writes
    run_cmd(8'hC2, 0, 16'h0, bn, any);
    run_cmd(8'h84, 1, 16'h0000, bn, any);
    chk("R6 disabled no busy", bn, 0);
    rd_word(4'h4, v, dmy);
    chk("R6 disabled word kept", v, 16'h5A3C);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule